// File: doc/BRIEF.md
# Bit-Serial Column Vector Adder

This block is a small compute memory whose storage is organised as rows of `COLS` bits, where every column is one independent word lane. Words are held transposed: bit k of every lane lives in the same row, so an operand of width n occupies n consecutive rows. A host port reads and writes whole rows. A command names three base rows (operand A, operand B, result) and a width, and a sequencer then walks down the rows one bit position per cycle. Every column works in parallel as a one-bit ALU.

For addition each column senses the A and B bits together and forms their AND and NOR. It derives XOR from those two values and adds its own carry latch. The column writes the sum bit into the result region and keeps the carry for the next row. The final carry is stored one row above the top sum bit, so an n-bit add produces n+1 result rows. Carries stay inside their column and never pass sideways. The same datapath can instead store plain column-wise AND, NOR or XOR rows, with no carry involved.

A one-cycle done pulse marks the end of every command. While a command runs, host accesses and new commands are dropped.

Top module: `colalu_top`

## Requirements
- R1: After reset `busy`, `done` and `host_rdata` are all 0.
- R2: A host write (`host_en`=1, `host_we`=1) stores `host_wdata` into row `host_addr`. A host read (`host_en`=1, `host_we`=0) presents that row on `host_rdata` one cycle later, and `host_rdata` holds its value until the next accepted read.
- R3: With `cmd_op`=0 (add) and width n, for every column c and every k < n, result row r+k receives bit k of A[c]+B[c], and row r+n receives bit n, which is the carry out. Here A[c] is the n-bit word formed from bit c of rows a..a+n-1 with row a as the least significant bit, and B[c] is formed the same way from rows b onward. No column affects another.
- R4: The per-column carry latches clear to 0 when an add command is accepted, so no carry from an earlier command reaches a new sum.
- R5: With `cmd_op`=1, for every k < n, row r+k receives the bitwise AND of rows a+k and b+k.
- R6: With `cmd_op`=2, for every k < n, row r+k receives the bitwise NOR of rows a+k and b+k.
- R7: With `cmd_op`=3, for every k < n, row r+k receives the bitwise XOR of rows a+k and b+k.
- R8: A command is accepted when `cmd_valid`=1, `busy`=0 and 1 <= `cmd_width` <= MAX_W. `busy` is 1 from the next cycle on. An add keeps `busy` high for n+1 cycles and a logic operation for n cycles. `done` is high for exactly one cycle, the first cycle after the last row write, and in that cycle `busy` is 0.
- R9: A command whose width is 0 or greater than MAX_W (16 by default) is ignored: `busy` stays 0, `done` does not pulse and no row changes.
- R10: While `busy` is 1, host writes do not change any row and host reads do not update `host_rdata`.
- R11: Row addresses wrap modulo ROWS (64 by default), so an operand may run past the top row and continue from row 0.
- R12: A command presented while `busy` is 1 is ignored and writes no row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_en | input | 1 | Host row access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ROW_AW (6) | Host row address |
| host_wdata | input | COLS (256) | Row data to write |
| host_rdata | output | COLS (256) | Registered row read data |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 0 add, 1 AND, 2 NOR, 3 XOR |
| cmd_a_row | input | ROW_AW (6) | Base row of operand A (bit 0) |
| cmd_b_row | input | ROW_AW (6) | Base row of operand B (bit 0) |
| cmd_r_row | input | ROW_AW (6) | Base row of the result |
| cmd_width | input | WID_W (5) | Operand width n |
| busy | output | 1 | Command running |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situations to reach are collisions with a running sequence: a host write, a host read or a second command that arrives in the middle of an add. It is just as hard to show that a carry left over from one add does not leak into the next. The directed tasks count cycles from acceptance and inject the host access or the competing command at chosen cycles inside the busy window. They then read the affected rows back through the host port. For the leftover carry, an all-ones add that leaves every carry latch set is followed at once by an all-zeros add, whose result rows must come back zero.

// File: rtl/colalu_pkg.sv
package colalu_pkg;
   typedef enum logic [1:0] {
      OP_ADD = 2'd0,
      OP_AND = 2'd1,
      OP_NOR = 2'd2,
      OP_XOR = 2'd3
   } colalu_op_e;

   typedef enum logic [2:0] {
      SEL_SUM   = 3'd0,
      SEL_CARRY = 3'd1,
      SEL_AND   = 3'd2,
      SEL_NOR   = 3'd3,
      SEL_XOR   = 3'd4
   } colalu_sel_e;
endpackage

// File: rtl/colalu_rowstore.sv
module colalu_rowstore #(
   parameter int COLS = 256,
   parameter int ROWS = 64,
   localparam int AW = $clog2(ROWS)
) (
   input  logic            clk,
   input  logic [AW-1:0]   rd_a_addr,
   input  logic [AW-1:0]   rd_b_addr,
   input  logic [AW-1:0]   rd_h_addr,
   input  logic            wr_en,
   input  logic [AW-1:0]   wr_addr,
   input  logic [COLS-1:0] wr_data,
   output logic [COLS-1:0] rd_a_data,
   output logic [COLS-1:0] rd_b_data,
   output logic [COLS-1:0] rd_h_data
);
   logic [COLS-1:0] mem [ROWS];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
   end

   // two rows sensed together for compute, one row for the host
   assign rd_a_data = mem[rd_a_addr];
   assign rd_b_data = mem[rd_b_addr];
   assign rd_h_data = mem[rd_h_addr];
endmodule

// File: rtl/colalu_lanes.sv
module colalu_lanes
   import colalu_pkg::*;
#(
   parameter int COLS           = 256,
   parameter bit XOR_FROM_SENSE = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [COLS-1:0] opnd_a,
   input  logic [COLS-1:0] opnd_b,
   input  colalu_sel_e     sel,
   input  logic            carry_clr,
   input  logic            carry_en,
   output logic [COLS-1:0] result,
   output logic [COLS-1:0] carry_q
);
   for (genvar c = 0; c < COLS; c++) begin : g_lane
      logic both, neither, diff, sum, cout, res, cq;

      assign both    = opnd_a[c] & opnd_b[c];
      assign neither = ~(opnd_a[c] | opnd_b[c]);

      if (XOR_FROM_SENSE) begin : g_xor_sense
         assign diff = ~(both | neither);
      end else begin : g_xor_direct
         assign diff = opnd_a[c] ^ opnd_b[c];
      end

      assign sum  = diff ^ cq;
      assign cout = both | (diff & cq);

      always_ff @(posedge clk) begin
         if (!rst_n)         cq <= 1'b0;
         else if (carry_clr) cq <= 1'b0;
         else if (carry_en)  cq <= cout;
      end

      always_comb begin
         unique case (sel)
            SEL_SUM:   res = sum;
            SEL_CARRY: res = cq;
            SEL_AND:   res = both;
            SEL_NOR:   res = neither;
            SEL_XOR:   res = diff;
            default:   res = 1'b0;
         endcase
      end

      assign result[c]  = res;
      assign carry_q[c] = cq;
   end
endmodule

// File: rtl/colalu_seq.sv
module colalu_seq
   import colalu_pkg::*;
#(
   parameter int ROWS  = 64,
   parameter int MAX_W = 16,
   localparam int AW = $clog2(ROWS),
   localparam int WW = $clog2(MAX_W + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_valid,
   input  colalu_op_e    cmd_op,
   input  logic [AW-1:0] cmd_a_row,
   input  logic [AW-1:0] cmd_b_row,
   input  logic [AW-1:0] cmd_r_row,
   input  logic [WW-1:0] cmd_width,
   output logic          busy,
   output logic          done,
   output logic [AW-1:0] row_a,
   output logic [AW-1:0] row_b,
   output logic [AW-1:0] row_w,
   output logic          wr_en,
   output colalu_sel_e   sel,
   output logic          carry_clr,
   output logic          carry_en
);
   colalu_op_e    op_q;
   logic [AW-1:0] a_q, b_q, r_q;
   logic [WW-1:0] width_q, step_q;
   logic          accept, top_row, last;

   assign accept  = cmd_valid && !busy && (cmd_width != '0)
                    && (cmd_width <= WW'(MAX_W));
   assign top_row = (step_q == width_q);
   assign last    = (op_q == OP_ADD) ? top_row : (step_q == width_q - 1'b1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         done    <= 1'b0;
         op_q    <= OP_ADD;
         a_q     <= '0;
         b_q     <= '0;
         r_q     <= '0;
         width_q <= '0;
         step_q  <= '0;
      end else begin
         done <= 1'b0;
         if (accept) begin
            busy    <= 1'b1;
            op_q    <= cmd_op;
            a_q     <= cmd_a_row;
            b_q     <= cmd_b_row;
            r_q     <= cmd_r_row;
            width_q <= cmd_width;
            step_q  <= '0;
         end else if (busy) begin
            if (last) begin
               busy <= 1'b0;
               done <= 1'b1;
            end else begin
               step_q <= step_q + 1'b1;
            end
         end
      end
   end

   // row addresses wrap naturally in AW bits
   assign row_a = a_q + AW'(step_q);
   assign row_b = b_q + AW'(step_q);
   assign row_w = r_q + AW'(step_q);
   assign wr_en = busy;

   always_comb begin
      unique case (op_q)
         OP_ADD:  sel = top_row ? SEL_CARRY : SEL_SUM;
         OP_AND:  sel = SEL_AND;
         OP_NOR:  sel = SEL_NOR;
         default: sel = SEL_XOR;
      endcase
   end

   assign carry_clr = accept && (cmd_op == OP_ADD);
   assign carry_en  = busy && (op_q == OP_ADD) && !top_row;
endmodule

// File: rtl/colalu_top.sv
module colalu_top
   import colalu_pkg::*;
#(
   parameter int COLS           = 256,
   parameter int ROWS           = 64,
   parameter int MAX_W          = 16,
   parameter bit XOR_FROM_SENSE = 1'b1,
   localparam int ROW_AW = $clog2(ROWS),
   localparam int WID_W  = $clog2(MAX_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_en,
   input  logic              host_we,
   input  logic [ROW_AW-1:0] host_addr,
   input  logic [COLS-1:0]   host_wdata,
   output logic [COLS-1:0]   host_rdata,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_op,
   input  logic [ROW_AW-1:0] cmd_a_row,
   input  logic [ROW_AW-1:0] cmd_b_row,
   input  logic [ROW_AW-1:0] cmd_r_row,
   input  logic [WID_W-1:0]  cmd_width,
   output logic              busy,
   output logic              done
);
   if (ROWS != (1 << ROW_AW)) begin : g_chk_rows
      $error("ROWS must be a power of two");
   end
   if (MAX_W < 1 || MAX_W + 1 > ROWS) begin : g_chk_width
      $error("MAX_W must be at least 1 and leave room for the carry row");
   end
   if (COLS < 1) begin : g_chk_cols
      $error("COLS must be positive");
   end

   logic [ROW_AW-1:0] row_a, row_b, row_w, st_waddr;
   logic [COLS-1:0]   opnd_a, opnd_b, lane_res, rd_h, carry_vec, st_wdata;
   logic              seq_we, carry_clr, carry_en, host_ok, st_we;
   colalu_sel_e       sel;

   assign host_ok  = host_en && !busy;
   assign st_we    = busy ? seq_we : (host_ok && host_we);
   assign st_waddr = busy ? row_w : host_addr;
   assign st_wdata = busy ? lane_res : host_wdata;

   colalu_seq #(.ROWS(ROWS), .MAX_W(MAX_W)) seq_i (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_op(colalu_op_e'(cmd_op)),
      .cmd_a_row(cmd_a_row), .cmd_b_row(cmd_b_row), .cmd_r_row(cmd_r_row),
      .cmd_width(cmd_width),
      .busy(busy), .done(done),
      .row_a(row_a), .row_b(row_b), .row_w(row_w), .wr_en(seq_we),
      .sel(sel), .carry_clr(carry_clr), .carry_en(carry_en)
   );

   colalu_rowstore #(.COLS(COLS), .ROWS(ROWS)) store_i (
      .clk(clk),
      .rd_a_addr(row_a), .rd_b_addr(row_b), .rd_h_addr(host_addr),
      .wr_en(st_we), .wr_addr(st_waddr), .wr_data(st_wdata),
      .rd_a_data(opnd_a), .rd_b_data(opnd_b), .rd_h_data(rd_h)
   );

   colalu_lanes #(.COLS(COLS), .XOR_FROM_SENSE(XOR_FROM_SENSE)) lanes_i (
      .clk(clk), .rst_n(rst_n),
      .opnd_a(opnd_a), .opnd_b(opnd_b), .sel(sel),
      .carry_clr(carry_clr), .carry_en(carry_en),
      .result(lane_res), .carry_q(carry_vec)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)                   host_rdata <= '0;
      else if (host_ok && !host_we) host_rdata <= rd_h;
   end
endmodule

// File: rtl/colalu_chk.sv
module colalu_chk #(
   parameter int COLS  = 256,
   parameter int MAX_W = 16,
   localparam int WW = $clog2(MAX_W + 1)
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cmd_valid,
   input logic [1:0]      cmd_op,
   input logic [WW-1:0]   cmd_width,
   input logic            busy,
   input logic            done,
   input logic [COLS-1:0] host_rdata,
   input logic [COLS-1:0] carry
);
   logic good_w, take;
   logic [WW:0] run_len;

   assign good_w = (cmd_width != '0) && (cmd_width <= WW'(MAX_W));
   assign take   = cmd_valid && !busy && good_w;

   always_ff @(posedge clk) begin
      if (!rst_n)    run_len <= '0;
      else if (busy) run_len <= run_len + 1'b1;
      else           run_len <= '0;
   end

   assert_busy_after_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> busy);
   assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_done_closes_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));
   assert_run_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (run_len <= (WW+1)'(MAX_W)));
   assert_bad_width_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !busy && !good_w) |=> !busy);
   assert_carry_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (take && cmd_op == 2'd0) |=> (carry == '0));
   assert_rdata_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(host_rdata));
endmodule

bind colalu_top colalu_chk #(.COLS(COLS), .MAX_W(MAX_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
   .cmd_width(cmd_width), .busy(busy), .done(done),
   .host_rdata(host_rdata), .carry(carry_vec)
);

// File: tb/colalu_top_tb_top.sv
module colalu_top_tb_top;
   localparam int COLS = 256;
   localparam int ROWS = 64;
   localparam int MAXW = 16;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            host_en = 1'b0, host_we = 1'b0;
   logic [5:0]      host_addr = '0;
   logic [COLS-1:0] host_wdata = '0;
   logic [COLS-1:0] host_rdata;
   logic            cmd_valid = 1'b0;
   logic [1:0]      cmd_op = '0;
   logic [5:0]      cmd_a_row = '0, cmd_b_row = '0, cmd_r_row = '0;
   logic [4:0]      cmd_width = '0;
   logic            busy, done;

   int checks = 0;
   int failures = 0;
   logic [COLS-1:0] mdl [ROWS];

   always #5 clk = ~clk;

   colalu_top dut_i (
      .clk(clk), .rst_n(rst_n), .host_en(host_en), .host_we(host_we),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_a_row(cmd_a_row),
      .cmd_b_row(cmd_b_row), .cmd_r_row(cmd_r_row), .cmd_width(cmd_width),
      .busy(busy), .done(done)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [COLS-1:0] act, input logic [COLS-1:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [COLS-1:0] rnd_row();
      logic [COLS-1:0] v;
      for (int i = 0; i < COLS / 32; i++) v[i*32 +: 32] = $urandom;
      return v;
   endfunction

   task automatic host_write(input int row, input logic [COLS-1:0] d);
      host_en = 1'b1; host_we = 1'b1; host_addr = 6'(row); host_wdata = d;
      @(negedge clk);
      host_en = 1'b0; host_we = 1'b0;
      mdl[row % ROWS] = d;
   endtask

   task automatic host_read(input int row, output logic [COLS-1:0] d);
      host_en = 1'b1; host_we = 1'b0; host_addr = 6'(row);
      @(negedge clk);
      host_en = 1'b0;
      d = host_rdata;
   endtask

   task automatic check_rows(input int base, input int cnt, input string req);
      logic [COLS-1:0] d;
      for (int k = 0; k < cnt; k++) begin
         host_read((base + k) % ROWS, d);
         check(d === mdl[(base + k) % ROWS], req, $sformatf("row %0d", (base + k) % ROWS),
               d, mdl[(base + k) % ROWS]);
      end
   endtask

   task automatic model_cmd(input int op, input int a, input int b, input int r, input int w);
      logic [COLS-1:0] tmp [17];
      for (int k = 0; k <= w; k++) tmp[k] = '0;
      if (op == 0) begin
         for (int c = 0; c < COLS; c++) begin
            int wa, wb, s;
            wa = 0; wb = 0;
            for (int k = 0; k < w; k++) begin
               wa |= int'(mdl[(a + k) % ROWS][c]) << k;
               wb |= int'(mdl[(b + k) % ROWS][c]) << k;
            end
            s = wa + wb;
            for (int k = 0; k <= w; k++) tmp[k][c] = s[k];
         end
         for (int k = 0; k <= w; k++) mdl[(r + k) % ROWS] = tmp[k];
      end else begin
         for (int k = 0; k < w; k++) begin
            logic [COLS-1:0] x, y;
            x = mdl[(a + k) % ROWS]; y = mdl[(b + k) % ROWS];
            tmp[k] = (op == 1) ? (x & y) : (op == 2) ? ~(x | y) : (x ^ y);
         end
         for (int k = 0; k < w; k++) mdl[(r + k) % ROWS] = tmp[k];
      end
   endtask

   // mode 0: plain; 1: host write+read while busy (R10); 2: second command while busy (R12)
   task automatic run_cmd(input int op, input int a, input int b, input int r, input int w,
                          input int mode);
      int cnt, len;
      logic [COLS-1:0] saved;
      saved = host_rdata;
      len = (op == 0) ? w + 1 : w;
      cmd_valid = 1'b1; cmd_op = 2'(op); cmd_a_row = 6'(a); cmd_b_row = 6'(b);
      cmd_r_row = 6'(r); cmd_width = 5'(w);
      @(negedge clk);
      cmd_valid = 1'b0;
      check(busy === 1'b1, "R8", "busy after accept", COLS'(busy), COLS'(1));
      cnt = 1;
      while (!done && cnt < 40) begin
         host_en = 1'b0; cmd_valid = 1'b0;
         if (mode == 1 && cnt == 2) begin
            host_en = 1'b1; host_we = 1'b1; host_addr = 6'd40; host_wdata = ~mdl[40];
         end
         if (mode == 1 && cnt == 3) begin
            host_en = 1'b1; host_we = 1'b0; host_addr = 6'd41;
         end
         if (mode == 1 && cnt == 4)
            check(host_rdata === saved, "R10", "rdata during busy", host_rdata, saved);
         if (mode == 2 && cnt == 2) begin
            cmd_valid = 1'b1; cmd_op = 2'd1; cmd_a_row = 6'd0; cmd_b_row = 6'd1;
            cmd_r_row = 6'd48; cmd_width = 5'd2;
         end
         @(negedge clk);
         cnt++;
      end
      host_en = 1'b0; host_we = 1'b0; cmd_valid = 1'b0;
      check(cnt == len + 1, "R8", "done timing", COLS'(cnt), COLS'(len + 1));
      check(busy === 1'b0, "R8", "busy low with done", COLS'(busy), COLS'(0));
      @(negedge clk);
      check(done === 1'b0, "R8", "done one cycle", COLS'(done), COLS'(0));
      model_cmd(op, a, b, r, w);
   endtask

   task automatic t_reset();
      check(busy === 1'b0 && done === 1'b0, "R1", "busy/done at reset",
            COLS'({busy, done}), COLS'(0));
      check(host_rdata === '0, "R1", "rdata at reset", host_rdata, '0);
   endtask

   task automatic t_fill();
      for (int i = 0; i < ROWS; i++) host_write(i, rnd_row());
      check_rows(0, 4, "R2");
      check_rows(60, 4, "R2");
   endtask

   task automatic t_add();
      // column 0 ripples a carry through every bit, column 1 stays zero
      logic [COLS-1:0] v;
      for (int k = 0; k < 8; k++) begin
         v = mdl[k]; v[0] = 1'b1; v[1] = 1'b0; host_write(k, v);
         v = mdl[16 + k]; v[0] = (k == 0); v[1] = 1'b0; host_write(16 + k, v);
      end
      run_cmd(0, 0, 16, 32, 8, 0);
      check_rows(32, 9, "R3");
      run_cmd(0, 0, 16, 33, MAXW, 0);
      check_rows(33, MAXW + 1, "R3");
   endtask

   task automatic t_carry_clear();
      host_write(50, '1); host_write(51, '1);
      run_cmd(0, 50, 51, 52, 1, 0);
      check_rows(52, 2, "R3");
      host_write(54, '0); host_write(55, '0);
      run_cmd(0, 54, 55, 56, 1, 0);
      check_rows(56, 2, "R4");
   endtask

   task automatic t_logic();
      run_cmd(1, 0, 8, 20, 4, 0);
      check_rows(20, 4, "R5");
      run_cmd(2, 2, 10, 24, 4, 0);
      check_rows(24, 4, "R6");
      run_cmd(3, 4, 12, 28, 4, 0);
      check_rows(28, 4, "R7");
   endtask

   task automatic t_bad_width();
      logic ok;
      for (int t = 0; t < 2; t++) begin
         cmd_valid = 1'b1; cmd_op = 2'd1; cmd_a_row = 6'd0; cmd_b_row = 6'd1;
         cmd_r_row = 6'd60; cmd_width = (t == 0) ? 5'd0 : 5'd17;
         @(negedge clk);
         cmd_valid = 1'b0;
         ok = 1'b1;
         for (int i = 0; i < 4; i++) begin
            if (busy !== 1'b0 || done !== 1'b0) ok = 1'b0;
            @(negedge clk);
         end
         check(ok, "R9", "bad width ignored", COLS'({busy, done}), COLS'(0));
      end
      check_rows(60, 1, "R9");
   endtask

   task automatic t_wrap();
      run_cmd(0, 60, 8, 20, 8, 0);
      check_rows(20, 9, "R11");
   endtask

   task automatic t_busy_host();
      logic [COLS-1:0] d;
      host_read(2, d);
      run_cmd(0, 0, 8, 16, 6, 1);
      check_rows(40, 1, "R10");
      check_rows(16, 7, "R3");
   endtask

   task automatic t_busy_cmd();
      run_cmd(0, 0, 8, 24, 3, 2);
      check_rows(48, 2, "R12");
      check_rows(24, 4, "R3");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_fill();
      t_add();
      t_carry_clear();
      t_logic();
      t_bad_width();
      t_wrap();
      t_busy_host();
      t_busy_cmd();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #2000000;
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule